// File: doc/BRIEF.md
# Bouncing Three-Light Indicator

This block drives three lamps (left, middle and right) so that exactly one of them is lit at a time and the lit position sweeps back and forth: left, middle, right, middle, left, and so on for as long as the clock runs. It has no data inputs. The sweep rate follows the clock, and a step-enable input lets the surrounding logic slow the movement without a second clock.

Because the middle lamp is passed in both directions, the lit position alone does not say what comes next. The state therefore holds the lit index together with a heading bit, which gives four reachable states. The lamps are decoded from the registered state alone, so they change only on a clock edge. A synchronous reset puts the sweep back at the left lamp, heading right.

Top module: `sweep_eye`

## Requirements
- R1: While `rst_i` is high at a rising edge, and in the cycle after that edge, only the left lamp is lit ({left_o, mid_o, right_o} = 3'b100).
- R2: Out of reset, exactly one of `left_o`, `mid_o`, `right_o` is high in every cycle.
- R3: A step (`tick_i` high at a rising edge, reset low) taken with the left lamp lit lights the middle lamp on the next cycle.
- R4: A step taken with the middle lamp lit, when the last end lamp lit before it was the left one, lights the right lamp.
- R5: A step taken with the right lamp lit lights the middle lamp on the next cycle.
- R6: A step taken with the middle lamp lit, when the last end lamp lit before it was the right one, lights the left lamp.
- R7: When `tick_i` is low at a rising edge and reset is low, the lamps keep their values through that edge.
- R8: The lamps depend only on the registered state: a pulse on `tick_i` that starts and ends between two rising edges does not change them.
- R9: Reset takes priority over `tick_i`: with both high at an edge, the left lamp is lit next, whatever the lamp before.
- R10: With `tick_i` held high, the lamp pattern repeats with a period of four steps and the middle lamp is lit twice in each period.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock; all state changes on its rising edge |
| rst_i | input | 1 | Synchronous reset, active high |
| tick_i | input | 1 | Step enable; the sweep advances one position on each edge where it is high |
| left_o | output | 1 | Left lamp, high means lit |
| mid_o | output | 1 | Middle lamp, high means lit |
| right_o | output | 1 | Right lamp, high means lit |

## Verification
The bench aims at the middle lamp, the place where a design that kept only the lit position would lose its heading and either bounce straight back to the end it came from or stick at one end. It holds `tick_i` low for runs of cycles to catch a design that advances anyway, and it pulses the step input between edges to expose lamps decoded from the input rather than the state. Reset is raised at both end lamps and at the middle with `tick_i` high, which catches a design that lets the step win over the reset or that returns to reset heading the wrong way.

// File: rtl/sweep_pkg.sv
package sweep_pkg;

    // Number of lamps along the sweep; the ports expose three.
    localparam int unsigned NUM_LAMPS = 3;
    localparam int unsigned IDX_W     = $clog2(NUM_LAMPS);

    localparam logic [IDX_W-1:0] POS_FIRST = '0;
    localparam logic [IDX_W-1:0] POS_LAST  = IDX_W'(NUM_LAMPS - 1);

    // Lit index plus heading: heading is needed because inner lamps are
    // crossed in both directions.
    typedef struct packed {
        logic [IDX_W-1:0] pos;
        logic             toward_last;
    } sweep_st_t;

    localparam sweep_st_t SWEEP_RESET = '{pos: POS_FIRST, toward_last: 1'b1};

endpackage

// File: rtl/sweep_step.sv
module sweep_step
    import sweep_pkg::*;
(
    input  sweep_st_t cur_i,
    input  logic      advance_i,
    output sweep_st_t nxt_o
);

    always_comb begin
        nxt_o = cur_i;
        if (advance_i) begin
            if (cur_i.toward_last) begin
                nxt_o.pos = cur_i.pos + 1'b1;
                // Arriving at the far end turns the heading around.
                if (cur_i.pos == POS_LAST - 1'b1) begin
                    nxt_o.toward_last = 1'b0;
                end
            end else begin
                nxt_o.pos = cur_i.pos - 1'b1;
                if (cur_i.pos == POS_FIRST + 1'b1) begin
                    nxt_o.toward_last = 1'b1;
                end
            end
        end
    end

endmodule

// File: rtl/sweep_decode.sv
module sweep_decode
    import sweep_pkg::*;
(
    input  logic [IDX_W-1:0]     pos_i,
    output logic [NUM_LAMPS-1:0] lamp_o
);

    // One comparator per lamp: lamp i is lit when the index equals i.
    for (genvar i = 0; i < NUM_LAMPS; i++) begin : g_lamp
        assign lamp_o[i] = (pos_i == IDX_W'(i));
    end

endmodule

// File: rtl/sweep_eye.sv
module sweep_eye
    import sweep_pkg::*;
(
    input  logic clk_i,
    input  logic rst_i,
    input  logic tick_i,
    output logic left_o,
    output logic mid_o,
    output logic right_o
);

    sweep_st_t             state_d;
    sweep_st_t             state_q;
    sweep_st_t             step_nxt;
    logic [NUM_LAMPS-1:0]  lamp;

    sweep_step u_step (
        .cur_i     (state_q),
        .advance_i (tick_i),
        .nxt_o     (step_nxt)
    );

    always_comb begin
        state_d = step_nxt;
        if (rst_i) begin
            state_d = SWEEP_RESET;
        end
    end

    always_ff @(posedge clk_i) begin
        state_q <= state_d;
    end

    // Moore outputs: decoded from the register only.
    sweep_decode u_decode (
        .pos_i  (state_q.pos),
        .lamp_o (lamp)
    );

    assign left_o  = lamp[0];
    assign mid_o   = lamp[1];
    assign right_o = lamp[2];

endmodule

// File: rtl/sweep_eye_chk.sv
module sweep_eye_chk (
    input logic clk_i,
    input logic rst_i,
    input logic tick_i,
    input logic left_o,
    input logic mid_o,
    input logic right_o
);

    logic [2:0] lamps;
    logic       last_end_left_q;

    assign lamps = {left_o, mid_o, right_o};

    // Remembers which end lamp was lit most recently.
    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            last_end_left_q <= 1'b1;
        end else if (left_o) begin
            last_end_left_q <= 1'b1;
        end else if (right_o) begin
            last_end_left_q <= 1'b0;
        end
    end

    assert_reset_left_R1: assert property (@(posedge clk_i) disable iff (rst_i)
        $past(rst_i) |-> (lamps == 3'b100));

    assert_one_lit_R2: assert property (@(posedge clk_i) disable iff (rst_i)
        !$past(rst_i) |-> ($countones(lamps) == 1));

    assert_left_to_mid_R3: assert property (@(posedge clk_i) disable iff (rst_i)
        (!$past(rst_i) && $past(tick_i) && $past(lamps) == 3'b100) |-> (lamps == 3'b010));

    assert_mid_to_right_R4: assert property (@(posedge clk_i) disable iff (rst_i)
        (!$past(rst_i) && $past(tick_i) && $past(lamps) == 3'b010 && last_end_left_q)
        |-> (lamps == 3'b001));

    assert_right_to_mid_R5: assert property (@(posedge clk_i) disable iff (rst_i)
        (!$past(rst_i) && $past(tick_i) && $past(lamps) == 3'b001) |-> (lamps == 3'b010));

    assert_mid_to_left_R6: assert property (@(posedge clk_i) disable iff (rst_i)
        (!$past(rst_i) && $past(tick_i) && $past(lamps) == 3'b010 && !last_end_left_q)
        |-> (lamps == 3'b100));

    assert_hold_R7: assert property (@(posedge clk_i) disable iff (rst_i)
        (!$past(rst_i) && !$past(tick_i)) |-> $stable(lamps));

endmodule

bind sweep_eye sweep_eye_chk chk_i (
    .clk_i   (clk_i),
    .rst_i   (rst_i),
    .tick_i  (tick_i),
    .left_o  (left_o),
    .mid_o   (mid_o),
    .right_o (right_o)
);

// File: tb/sweep_eye_tb.sv
`timescale 1ns/1ps
module sweep_eye_tb_top;

    logic clk = 1'b0;
    logic rst;
    logic tick;
    logic left_l, mid_l, right_l;

    int n_checks = 0;
    int n_fail   = 0;

    // Bench reference: index 0..2 (left..right) and heading.
    int ref_pos;
    bit ref_right;

    always #10 clk = ~clk;   // 50 MHz

    sweep_eye dut_i (
        .clk_i   (clk),
        .rst_i   (rst),
        .tick_i  (tick),
        .left_o  (left_l),
        .mid_o   (mid_l),
        .right_o (right_l)
    );

    function automatic logic [2:0] exp_lamps(int pos);
        return 3'b100 >> pos;
    endfunction

    task automatic check(bit ok, string tag, logic [2:0] act, logic [2:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: lamps=%b expected=%b at %0t", tag, act, exp, $time);
        end
    endtask

    // Apply one edge with given inputs, update the model, compare.
    task automatic step(bit t, bit r);
        string tag;
        logic [2:0] got;
        tick = t;
        rst  = r;
        if (r) begin
            tag = "R9"; ref_pos = 0; ref_right = 1'b1;
        end else if (!t) begin
            tag = "R7";
        end else if (ref_pos == 0) begin
            tag = "R3"; ref_pos = 1;
        end else if (ref_pos == 2) begin
            tag = "R5"; ref_pos = 1; ref_right = 1'b0;
        end else if (ref_right) begin
            tag = "R4"; ref_pos = 2;
        end else begin
            tag = "R6"; ref_pos = 0; ref_right = 1'b1;
        end
        @(negedge clk);
        got = {left_l, mid_l, right_l};
        check(got == exp_lamps(ref_pos), tag, got, exp_lamps(ref_pos));
        check($countones(got) == 1, "R2", got, exp_lamps(ref_pos));
    endtask

    initial begin
        #4_000_000;
        n_fail++;
        $display("FAIL watchdog: lamps=%b expected=done", {left_l, mid_l, right_l});
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        logic [2:0] snap;
        logic [2:0] period [4];
        void'($urandom(32'd1234));
        rst  = 1'b1;
        tick = 1'b1;
        ref_pos = 0; ref_right = 1'b1;
        repeat (3) @(negedge clk);
        // R1: reset held, step input high, left lamp lit
        snap = {left_l, mid_l, right_l};
        check(snap == 3'b100, "R1", snap, 3'b100);
        step(1'b0, 1'b0);   // R1: first cycle after release still left

        // Full sweep with tick held high; R10 periodicity
        for (int k = 0; k < 4; k++) begin
            step(1'b1, 1'b0);
            period[k] = {left_l, mid_l, right_l};
        end
        for (int k = 0; k < 4; k++) begin
            step(1'b1, 1'b0);
            snap = {left_l, mid_l, right_l};
            check(snap == period[k], "R10", snap, period[k]);
        end
        check(period[0] == 3'b010 && period[2] == 3'b010, "R10",
              {period[0][1], period[2][1], 1'b0}, 3'b110);

        // Hold at middle heading right, then continue (R7, R4)
        step(1'b1, 1'b0);
        repeat (3) step(1'b0, 1'b0);
        step(1'b1, 1'b0);
        repeat (2) step(1'b0, 1'b0);
        step(1'b1, 1'b0);

        // R8: short step pulse strictly between edges
        tick = 1'b0;
        snap = {left_l, mid_l, right_l};
        #3 tick = 1'b1;
        #2 tick = 1'b0;
        check({left_l, mid_l, right_l} == snap, "R8", {left_l, mid_l, right_l}, snap);
        @(negedge clk);
        check({left_l, mid_l, right_l} == snap, "R8", {left_l, mid_l, right_l}, snap);

        // R9: reset with tick high at right and at middle
        while (ref_pos != 2) step(1'b1, 1'b0);
        step(1'b1, 1'b1);
        step(1'b1, 1'b0);
        step(1'b1, 1'b1);
        step(1'b1, 1'b0);
        step(1'b1, 1'b0);
        step(1'b1, 1'b0);   // middle heading left
        step(1'b1, 1'b1);

        // Random stimulus
        for (int k = 0; k < 3000; k++) begin
            step(1'($urandom % 2), ($urandom % 64) == 0);
        end

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule